// File: doc/BRIEF.md
# Asynchronous SRAM Write Strobe Sequencer

This block sits between a synchronous host and one port of an external asynchronous static RAM. The host presents an address, a 16-bit data word, two byte-lane enables, a write-style select and an output-enable policy. The block turns that into a timed sequence on the RAM pins, with every interval counted in clock cycles: address setup, write pulse, and a release phase that covers data hold and address hold.

Two write styles are available. In the first, chip enable goes low with the address setup and the read/write line forms the write pulse. In the second, read/write and chip enable fall together, so the write is framed by chip enable. When the host asks for output enable to stay low in the first style, the RAM may still be driving its I/O pins as the pulse starts. The block then waits a turn-off interval before it drives data, and it stretches the pulse so that the data setup still fits inside it. All pin outputs come from registers, so the strobes never glitch.

Top module: `sram_wr_seq`

## Requirements
- R1: After reset, busy and done are low, every active-low strobe (chip enable, read/write, upper, lower, output enable, semaphore select) is high and the data drive enable is low.
- R2: A request is taken only on a clock edge where req_valid is high and busy is low. Requests made while busy is high are ignored, and the address and data on the RAM pins keep the values of the accepted request.
- R3: The RAM address pins change only in cycles where the read/write line is high.
- R4: Semaphore select stays high. While a write is in progress (setup and pulse), the upper strobe is low exactly when req_be[1] was set and the lower strobe is low exactly when req_be[0] was set.
- R5: With req_mode=0 (read/write-framed), chip enable is low and read/write is high for T_AS cycles after acceptance. Read/write is then low, with chip enable low, for the whole pulse.
- R6: With req_mode=0, the pulse lasts max(T_PW, T_HZ+T_SD) cycles when req_oe_low=1 and max(T_PW, T_SD) cycles when req_oe_low=0.
- R7: With req_mode=1 (enable-framed), chip enable and read/write both stay high for T_AS cycles and then fall in the same cycle for a pulse of max(T_PW, T_SD) cycles. Read/write is never low while chip enable is high.
- R8: The data drive enable is high during the pulse, starting T_HZ cycles into the pulse when req_mode=0 and req_oe_low=1, and from its first cycle otherwise. It stays high for T_HD cycles after the pulse. While it is high, ram_dq_o carries the accepted data.
- R9: After the pulse comes a release phase of max(T_HD, T_HA) cycles, in which chip enable, read/write, both byte strobes and output enable are high and the address is held.
- R10: busy is high from the cycle after acceptance to the end of the release phase. done is high for exactly one cycle, the first cycle after the release phase, and busy is low in that cycle.
- R11: Output enable is low during setup and pulse when req_oe_low=1, and high in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request |
| req_addr | input | ADDR_W | Write address |
| req_data | input | DATA_W | Write data |
| req_be | input | 2 | Byte enables, bit 1 upper and bit 0 lower |
| req_mode | input | 1 | 0 read/write-framed, 1 enable-framed |
| req_oe_low | input | 1 | 1 holds output enable low during the write |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| ram_addr | output | ADDR_W | RAM address |
| ram_ce_n | output | 1 | Chip enable, active low |
| ram_sem_n | output | 1 | Semaphore select, held high |
| ram_rw_n | output | 1 | Read/write, low for write |
| ram_ub_n | output | 1 | Upper byte strobe, active low |
| ram_lb_n | output | 1 | Lower byte strobe, active low |
| ram_oe_n | output | 1 | Output enable, active low |
| ram_dq_o | output | DATA_W | Data to drive on the RAM bus |
| ram_dq_oe | output | 1 | Data bus drive enable |

## Verification
The bench builds the block with T_AS=1, T_PW=4, T_SD=2, T_HZ=3, T_HD=1 and T_HA=3. The minimum setup checks the one-cycle edge of the counter. Because T_HZ+T_SD exceeds T_PW, the output-enable-low pulse is stretched to 5 cycles, against 4 in the other cases, so the stretch is directly visible. The address hold is longer than the data hold, so the drive enable drops in the middle of the release phase. Every combination of write style, output-enable policy and byte enables is compared cycle by cycle, along with requests injected while busy and back-to-back acceptance.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_PULSE = 2'd2,
    PH_HOLD  = 2'd3
  } wr_phase_e;

  // Active-low pin levels plus the data drive enable.
  typedef struct packed {
    logic ce_n;
    logic rw_n;
    logic ub_n;
    logic lb_n;
    logic oe_n;
    logic dq_oe;
  } pin_set_t;

  localparam pin_set_t PINS_IDLE = '{ce_n: 1'b1, rw_n: 1'b1, ub_n: 1'b1,
                                     lb_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_wr_timer.sv
module sram_wr_timer #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_d
);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/sram_wr_pins.sv
module sram_wr_pins
  import sram_wr_pkg::*;
#(
  parameter int unsigned CNT_W = 3,
  parameter int unsigned T_HZ  = 2,
  parameter int unsigned T_HD  = 1
) (
  input  wr_phase_e        phase,
  input  logic [CNT_W-1:0] cnt,
  input  logic             mode,
  input  logic             oe_low,
  input  logic [1:0]       be,
  output pin_set_t         pins
);

  logic [CNT_W-1:0] drive_start;

  // Turn-off wait only when the RAM may be driving as the pulse starts.
  always_comb begin
    drive_start = (!mode && oe_low) ? CNT_W'(T_HZ) : '0;
  end

  always_comb begin
    pins = PINS_IDLE;
    unique case (phase)
      PH_SETUP: begin
        pins.ce_n = mode;
        pins.ub_n = ~be[1];
        pins.lb_n = ~be[0];
        pins.oe_n = ~oe_low;
      end
      PH_PULSE: begin
        pins.ce_n  = 1'b0;
        pins.rw_n  = 1'b0;
        pins.ub_n  = ~be[1];
        pins.lb_n  = ~be[0];
        pins.oe_n  = ~oe_low;
        pins.dq_oe = (cnt >= drive_start);
      end
      PH_HOLD: begin
        pins.dq_oe = (cnt < CNT_W'(T_HD));
      end
      default: pins = PINS_IDLE;
    endcase
  end

endmodule

// File: rtl/sram_wr_seq.sv
module sram_wr_seq
  import sram_wr_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned T_AS   = 2,
  parameter int unsigned T_PW   = 3,
  parameter int unsigned T_SD   = 2,
  parameter int unsigned T_HD   = 1,
  parameter int unsigned T_HA   = 2,
  parameter int unsigned T_HZ   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [1:0]        req_be,
  input  logic              req_mode,
  input  logic              req_oe_low,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_ce_n,
  output logic              ram_sem_n,
  output logic              ram_rw_n,
  output logic              ram_ub_n,
  output logic              ram_lb_n,
  output logic              ram_oe_n,
  output logic [DATA_W-1:0] ram_dq_o,
  output logic              ram_dq_oe
);

  localparam int unsigned P_PLAIN = max2(T_PW, T_SD);
  localparam int unsigned P_TURN  = max2(T_PW, T_HZ + T_SD);
  localparam int unsigned H_LEN   = max2(T_HD, T_HA);
  localparam int unsigned MAX_LEN = max2(max2(T_AS, P_TURN), H_LEN);
  localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);

  wr_phase_e         phase_q, phase_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, pulse_last;
  logic              cnt_clr, cnt_en, accept, done_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [1:0]        be_q, be_d;
  logic              mode_q, mode_d, oel_q, oel_d;
  pin_set_t          pins_d, pins_q;

  assign accept = req_valid && (phase_q == PH_IDLE);
  assign cnt_en = (phase_q != PH_IDLE);

  // Request fields as they will be after this edge.
  always_comb begin
    be_d   = accept ? req_be     : be_q;
    mode_d = accept ? req_mode   : mode_q;
    oel_d  = accept ? req_oe_low : oel_q;
  end

  always_comb begin
    pulse_last = (!mode_q && oel_q) ? CNT_W'(P_TURN - 1) : CNT_W'(P_PLAIN - 1);
  end

  // Next-state logic
  always_comb begin
    phase_d = phase_q;
    cnt_clr = 1'b0;
    done_d  = 1'b0;
    unique case (phase_q)
      PH_IDLE: if (accept) begin
        phase_d = PH_SETUP;
        cnt_clr = 1'b1;
      end
      PH_SETUP: if (cnt_q == CNT_W'(T_AS - 1)) begin
        phase_d = PH_PULSE;
        cnt_clr = 1'b1;
      end
      PH_PULSE: if (cnt_q == pulse_last) begin
        phase_d = PH_HOLD;
        cnt_clr = 1'b1;
      end
      PH_HOLD: if (cnt_q == CNT_W'(H_LEN - 1)) begin
        phase_d = PH_IDLE;
        cnt_clr = 1'b1;
        done_d  = 1'b1;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  sram_wr_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (cnt_en),
    .clr   (cnt_clr),
    .cnt_q (cnt_q),
    .cnt_d (cnt_d)
  );

  // Pin levels are decoded from the next state so the pins come out of flops.
  sram_wr_pins #(.CNT_W(CNT_W), .T_HZ(T_HZ), .T_HD(T_HD)) u_pins (
    .phase  (phase_d),
    .cnt    (cnt_d),
    .mode   (mode_d),
    .oe_low (oel_d),
    .be     (be_d),
    .pins   (pins_d)
  );

  // Register processes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      done    <= 1'b0;
      pins_q  <= PINS_IDLE;
    end else begin
      phase_q <= phase_d;
      done    <= done_d;
      pins_q  <= pins_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      be_q   <= '0;
      mode_q <= 1'b0;
      oel_q  <= 1'b0;
    end else if (accept) begin
      addr_q <= req_addr;
      data_q <= req_data;
      be_q   <= req_be;
      mode_q <= req_mode;
      oel_q  <= req_oe_low;
    end
  end

  assign busy      = (phase_q != PH_IDLE);
  assign ram_addr  = addr_q;
  assign ram_dq_o  = data_q;
  assign ram_sem_n = 1'b1;
  assign ram_ce_n  = pins_q.ce_n;
  assign ram_rw_n  = pins_q.rw_n;
  assign ram_ub_n  = pins_q.ub_n;
  assign ram_lb_n  = pins_q.lb_n;
  assign ram_oe_n  = pins_q.oe_n;
  assign ram_dq_oe = pins_q.dq_oe;

  // R3: address only moves while read/write is high
  a_r3_addr_moves_rw_high: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_addr != $past(ram_addr)) |-> ram_rw_n);

  // R2: no new request is taken while busy
  a_r2_busy_freezes_addr: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> $stable(ram_addr));

  // R10: done is a single-cycle pulse outside the busy window
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R7: read/write is never low without chip enable
  a_r7_rw_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_rw_n |-> !ram_ce_n);

  // R8: no drive while the RAM may be driving its outputs
  a_r8_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_dq_oe && !ram_ce_n && ram_rw_n && !ram_oe_n));

endmodule

// File: tb/sram_wr_seq_tb.sv
module sram_wr_seq_tb;

  localparam int unsigned AW = 12;
  localparam int unsigned DW = 16;
  localparam int unsigned B_AS = 1;
  localparam int unsigned B_PW = 4;
  localparam int unsigned B_SD = 2;
  localparam int unsigned B_HD = 1;
  localparam int unsigned B_HA = 3;
  localparam int unsigned B_HZ = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_data;
  logic [1:0]    req_be;
  logic          req_mode, req_oe_low;
  logic          busy, done;
  logic [AW-1:0] ram_addr;
  logic          ram_ce_n, ram_sem_n, ram_rw_n, ram_ub_n, ram_lb_n, ram_oe_n;
  logic [DW-1:0] ram_dq_o;
  logic          ram_dq_oe;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  sram_wr_seq #(
    .ADDR_W(AW), .DATA_W(DW), .T_AS(B_AS), .T_PW(B_PW), .T_SD(B_SD),
    .T_HD(B_HD), .T_HA(B_HA), .T_HZ(B_HZ)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_data(req_data), .req_be(req_be), .req_mode(req_mode),
    .req_oe_low(req_oe_low), .busy(busy), .done(done), .ram_addr(ram_addr),
    .ram_ce_n(ram_ce_n), .ram_sem_n(ram_sem_n), .ram_rw_n(ram_rw_n),
    .ram_ub_n(ram_ub_n), .ram_lb_n(ram_lb_n), .ram_oe_n(ram_oe_n),
    .ram_dq_o(ram_dq_o), .ram_dq_oe(ram_dq_oe)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int unsigned mx(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned pulse_len(input bit md, input bit oel);
    return (!md && oel) ? mx(B_PW, B_HZ + B_SD) : mx(B_PW, B_SD);
  endfunction

  // Expected {ce_n, rw_n, ub_n, lb_n, oe_n, dq_oe} in cycle j after acceptance
  function automatic logic [5:0] exp_pins(input int unsigned j, input bit md,
                                          input bit oel, input logic [1:0] be);
    int unsigned p, h, c, w;
    p = pulse_len(md, oel);
    h = mx(B_HD, B_HA);
    if (j < B_AS)
      return {md, 1'b1, ~be[1], ~be[0], ~oel, 1'b0};
    if (j < B_AS + p) begin
      c = j - B_AS;
      w = (!md && oel) ? B_HZ : 0;
      return {1'b0, 1'b0, ~be[1], ~be[0], ~oel, (c >= w)};
    end
    if (j < B_AS + p + h) begin
      c = j - B_AS - p;
      return {5'b11111, (c < B_HD)};
    end
    return 6'b111110;
  endfunction

  // R3 monitor: every address change must see read/write high
  logic [AW-1:0] prev_addr;
  always @(negedge clk) begin
    if (rst_n && (ram_addr != prev_addr))
      chk(ram_rw_n == 1'b1, "R3", "rw_n at addr change", 32'(ram_rw_n), 32'd1);
    prev_addr <= ram_addr;
  end

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic [1:0] be, input bit md, input bit oel,
                          input bit inject);
    int unsigned total;
    logic [5:0] e;
    logic [5:0] got;
    string tcr;
    total = B_AS + pulse_len(md, oel) + mx(B_HD, B_HA);
    while (busy) @(negedge clk);
    req_addr = a; req_data = d; req_be = be; req_mode = md; req_oe_low = oel;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int unsigned j = 0; j < total; j++) begin
      e   = exp_pins(j, md, oel, be);
      got = {ram_ce_n, ram_rw_n, ram_ub_n, ram_lb_n, ram_oe_n, ram_dq_oe};
      if (j >= total - mx(B_HD, B_HA))      tcr = "R9";
      else if (md)                           tcr = "R7";
      else if (j >= B_AS)                    tcr = "R6";
      else                                   tcr = "R5";
      chk(got[5:4] == e[5:4], tcr, "ce_n,rw_n", 32'(got[5:4]), 32'(e[5:4]));
      chk(got[3:2] == e[3:2], "R4", "ub_n,lb_n", 32'(got[3:2]), 32'(e[3:2]));
      chk(got[1] == e[1], "R11", "oe_n", 32'(got[1]), 32'(e[1]));
      chk(got[0] == e[0], "R8", "dq_oe", 32'(got[0]), 32'(e[0]));
      if (e[0]) chk(ram_dq_o == d, "R8", "dq data", 32'(ram_dq_o), 32'(d));
      chk(ram_addr == a, "R2", "addr", 32'(ram_addr), 32'(a));
      chk(ram_sem_n == 1'b1, "R4", "sem_n", 32'(ram_sem_n), 32'd1);
      chk(busy == 1'b1 && done == 1'b0, "R10", "busy,done", {30'd0, busy, done}, 32'd2);
      if (inject && j == 0) begin
        req_valid = 1'b1; req_addr = ~a; req_data = ~d; req_mode = ~md;
      end
      if (inject && j == total - 1) req_valid = 1'b0;
      @(posedge clk);
      @(negedge clk);
    end
    chk(done == 1'b1 && busy == 1'b0, "R10", "done pulse", {30'd0, busy, done}, 32'd1);
    got = {ram_ce_n, ram_rw_n, ram_ub_n, ram_lb_n, ram_oe_n, ram_dq_oe};
    chk(got == 6'b111110, "R9", "idle pins", 32'(got), 32'h3e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R10 watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int unsigned seed_out;
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_data = '0;
    req_be = 2'b00; req_mode = 1'b0; req_oe_low = 1'b0;
    seed_out = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk({busy, done} == 2'b00, "R1", "busy,done", 32'({busy, done}), 32'd0);
    chk({ram_ce_n, ram_rw_n, ram_ub_n, ram_lb_n, ram_oe_n, ram_sem_n} == 6'h3f,
        "R1", "strobes", 32'({ram_ce_n, ram_rw_n, ram_ub_n, ram_lb_n, ram_oe_n, ram_sem_n}), 32'h3f);
    chk(ram_dq_oe == 1'b0, "R1", "dq_oe", 32'(ram_dq_oe), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1", "busy after release", 32'(busy), 32'd0);
    // Directed: every style and policy, several lane patterns
    do_write(12'h123, 16'hA55A, 2'b11, 1'b0, 1'b1, 1'b0); // R6 stretched pulse
    do_write(12'h456, 16'h1234, 2'b10, 1'b0, 1'b0, 1'b0); // R5 plain pulse
    do_write(12'h789, 16'hBEEF, 2'b01, 1'b1, 1'b1, 1'b0); // R7 with OE low
    do_write(12'hABC, 16'h0F0F, 2'b11, 1'b1, 1'b0, 1'b0); // R7 with OE high
    do_write(12'h000, 16'hFFFF, 2'b00, 1'b0, 1'b1, 1'b0); // R4 no lane
    do_write(12'hFFF, 16'h8001, 2'b11, 1'b0, 1'b1, 1'b1); // R2 ignore while busy
    do_write(12'h5A5, 16'h7E7E, 2'b10, 1'b1, 1'b0, 1'b1); // R2 ignore while busy
    do_write(12'h5A5, 16'h0001, 2'b01, 1'b0, 1'b0, 1'b0); // R3 same address
    // Random mix
    for (int k = 0; k < 60; k++) begin
      do_write(12'($urandom), 16'($urandom), 2'($urandom), 1'($urandom),
               1'($urandom), 1'($urandom % 4 == 0));
    end
    @(negedge clk);
    chk(done == 1'b0, "R10", "done dropped", 32'(done), 32'd0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule